// File: doc/BRIEF.md
# Console Keyboard and Display Register Controller

This block sits on the memory bus of a 16-bit processor and presents a keyboard input port and a display output port as four device registers inside the memory map. Each port has a status register and a data register. A load from a device address returns device state. A load from any other address passes the memory's read data through unchanged, so the block also serves as the read-data multiplexer in front of the processor's memory data register.

Both ports use a ready-bit interlock, and the interlock acts on both sides. When the keyboard has delivered a character, it accepts no further characters until software reads the data register. While the display is still busy with the previous character, any store to the display data register is dropped. Software can poll the ready bits. It can also set a per-port enable bit and use the interrupt request that the port raises while ready and enable are both 1.

Top module: `con_io_ctrl`

## Requirements
- R1: After reset, keyboard status reads 0x0000, display status reads 0x8000, both interrupt requests are 0 and no display strobe is issued.
- R2: A keyboard strobe while keyboard ready (status bit 15) is 0 loads the 8-bit code into keyboard data bits [7:0] on that clock edge. From then on, bits [15:8] read as zero and keyboard ready reads as 1.
- R3: While keyboard ready is 1, incoming keyboard strobes are discarded and the keyboard data register keeps its value.
- R4: A bus read (read enable high) of keyboard data at 0xFE02 clears keyboard ready on that edge, after which the next strobe is captured again. A strobe that arrives in the same cycle as the clearing read is discarded.
- R5: A bus write to display data at 0xFE06 while display ready is 1 produces a one-cycle display strobe in the next cycle, carrying write data bits [7:0], and clears display ready (status bit 15).
- R6: A bus write to display data while display ready is 0 is ignored: no strobe is issued and the output code is unchanged.
- R7: A display acknowledge pulse sets display ready to 1 on the next edge, including when it arrives in the same cycle as an ignored write.
- R8: Bus writes to keyboard status at 0xFE00 or display status at 0xFE04 change only the interrupt-enable bit (bit 14). The ready bit cannot be written, and all status bits other than 15 and 14 read as zero.
- R9: Each port's interrupt request is 1 exactly when that port's ready bit and enable bit are both 1.
- R10: The read-data output shows device data whenever the address equals one of the four device addresses. For any other address, including odd neighbours such as 0xFE01, it shows memory read data.
- R11: Bus writes to keyboard data have no effect, and display data reads as 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | Bus address |
| bus_rd | input | 1 | Read enable; triggers read side effects |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 16 | Write data |
| mem_rdata | input | 16 | Read data from memory |
| bus_rdata | output | 16 | Read data to the processor |
| key_code | input | 8 | Character code from the keyboard source |
| key_stb | input | 1 | Keyboard character-valid strobe |
| disp_code | output | 8 | Character code to the display sink |
| disp_stb | output | 1 | Display write strobe, one cycle |
| disp_ack | input | 1 | Display-done acknowledge |
| key_irq | output | 1 | Keyboard interrupt request |
| disp_irq | output | 1 | Display interrupt request |

## Verification
The assertions check the handshake rules of each port on every cycle: capture when idle, hold while ready, clear on a data read, a single strobe per accepted store, no strobe for a store to a busy display, and re-arming on acknowledge. They also check that at most one device register is decoded at a time. Other behaviours only show up when the bench observes whole register words on the read path. These are the exact bit layouts, the zero upper bits, the ready bit surviving a status write, the mux falling back to memory, and recovery from reset in the middle of a run. The bench's scenarios cover those.

// File: rtl/con_io_pkg.sv
package con_io_pkg;

    localparam int WORD_W  = 16;
    localparam int CHAR_W  = 8;
    localparam int RDY_POS = 15;
    localparam int IEN_POS = 14;
    localparam int NUM_REG = 4;

    typedef struct packed {
        logic ddat;
        logic dsta;
        logic kdat;
        logic ksta;
    } dev_sel_t;

    function automatic logic [WORD_W-1:0] status_word(input logic rdy, input logic ien);
        logic [WORD_W-1:0] w;
        w          = '0;
        w[RDY_POS] = rdy;
        w[IEN_POS] = ien;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] char_word(input logic [CHAR_W-1:0] c);
        return {{(WORD_W-CHAR_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/con_io_decode.sv
module con_io_decode
    import con_io_pkg::*;
#(
    parameter int              ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'hFE00,
    parameter int              STRIDE = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output dev_sel_t          sel
);

    logic [NUM_REG-1:0] hit;

    for (genvar i = 0; i < NUM_REG; i++) begin : g_cmp
        localparam logic [ADDR_W-1:0] OFS = ADDR_W'(i * STRIDE);
        assign hit[i] = (addr == BASE + OFS);
    end

    assign sel = dev_sel_t'(hit);

    // R10: at most one device register decoded for any address
    always_comb begin
        a_r10_one_select: assert ($onehot0(hit));
    end

endmodule

// File: rtl/con_io_kbd.sv
module con_io_kbd
    import con_io_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHAR_W-1:0] char_in,
    input  logic              char_stb,
    input  logic              data_rd,
    input  logic              stat_wr,
    input  logic              ien_wdata,
    output logic              rdy,
    output logic              ien,
    output logic [CHAR_W-1:0] data
);

    typedef struct packed {
        logic              rdy;
        logic              ien;
        logic [CHAR_W-1:0] data;
    } kbd_st_t;

    kbd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.rdy) begin
            if (data_rd) st_d.rdy = 1'b0;
        end else if (char_stb) begin
            st_d.rdy  = 1'b1;
            st_d.data = char_in;
        end
        if (stat_wr) st_d.ien = ien_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdy  = st_q.rdy;
    assign ien  = st_q.ien;
    assign data = st_q.data;

    // R2: idle port captures a strobed character
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && char_stb) |=> (rdy && data == $past(char_in)));

    // R3: full port ignores strobes
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !data_rd) |=> (rdy && $stable(data)));

    // R4: data read releases the port
    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && data_rd) |=> !rdy);

endmodule

// File: rtl/con_io_disp.sv
module con_io_disp
    import con_io_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [CHAR_W-1:0] wchar,
    input  logic              ack,
    input  logic              stat_wr,
    input  logic              ien_wdata,
    output logic              rdy,
    output logic              ien,
    output logic              out_stb,
    output logic [CHAR_W-1:0] out_code
);

    typedef struct packed {
        logic              busy;
        logic              ien;
        logic              stb;
        logic [CHAR_W-1:0] code;
    } disp_st_t;

    disp_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (!st_q.busy) begin
            if (data_wr) begin
                st_d.busy = 1'b1;
                st_d.stb  = 1'b1;
                st_d.code = wchar;
            end
        end else if (ack) begin
            st_d.busy = 1'b0;
        end
        if (stat_wr) st_d.ien = ien_wdata;
    end

    // busy is stored so that the reset value 0 means "ready"
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdy      = !st_q.busy;
    assign ien      = st_q.ien;
    assign out_stb  = st_q.stb;
    assign out_code = st_q.code;

    // R5: accepted store gives a strobe and drops ready
    a_r5_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && data_wr) |=> (out_stb && !rdy && out_code == $past(wchar)));

    // R5: strobe never lasts two cycles
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_stb |=> !out_stb);

    // R6: store to a busy display is dropped
    a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && data_wr) |=> (!out_stb && $stable(out_code)));

    // R7: acknowledge re-arms the display
    a_r7_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> rdy);

endmodule

// File: rtl/con_io_ctrl.sv
module con_io_ctrl
    import con_io_pkg::*;
#(
    parameter logic [15:0] DEV_BASE = 16'hFE00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [15:0] bus_wdata,
    input  logic [15:0] mem_rdata,
    output logic [15:0] bus_rdata,
    input  logic [7:0]  key_code,
    input  logic        key_stb,
    output logic [7:0]  disp_code,
    output logic        disp_stb,
    input  logic        disp_ack,
    output logic        key_irq,
    output logic        disp_irq
);

    dev_sel_t          sel;
    logic              k_rdy, k_ien, d_rdy, d_ien;
    logic [CHAR_W-1:0] k_data;

    con_io_decode #(.ADDR_W(WORD_W), .BASE(DEV_BASE), .STRIDE(2)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    con_io_kbd u_kbd (
        .clk       (clk),
        .rst_n     (rst_n),
        .char_in   (key_code),
        .char_stb  (key_stb),
        .data_rd   (bus_rd && sel.kdat),
        .stat_wr   (bus_wr && sel.ksta),
        .ien_wdata (bus_wdata[IEN_POS]),
        .rdy       (k_rdy),
        .ien       (k_ien),
        .data      (k_data)
    );

    con_io_disp u_disp (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_wr   (bus_wr && sel.ddat),
        .wchar     (bus_wdata[CHAR_W-1:0]),
        .ack       (disp_ack),
        .stat_wr   (bus_wr && sel.dsta),
        .ien_wdata (bus_wdata[IEN_POS]),
        .rdy       (d_rdy),
        .ien       (d_ien),
        .out_stb   (disp_stb),
        .out_code  (disp_code)
    );

    always_comb begin
        if (sel.ksta)      bus_rdata = status_word(k_rdy, k_ien);
        else if (sel.kdat) bus_rdata = char_word(k_data);
        else if (sel.dsta) bus_rdata = status_word(d_rdy, d_ien);
        else if (sel.ddat) bus_rdata = '0;
        else               bus_rdata = mem_rdata;
    end

    assign key_irq  = k_rdy && k_ien;
    assign disp_irq = d_rdy && d_ien;

    // R9: an interrupt request always shows up in the readable status word
    a_r9_key_irq_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (key_irq && sel.ksta) |-> (bus_rdata[RDY_POS] && bus_rdata[IEN_POS]));

    // R10: non-device address always passes memory data
    a_r10_mem_path: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |-> (bus_rdata == mem_rdata));

endmodule

// File: tb/con_io_ctrl_test.sv
module con_io_ctrl_test;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [15:0] addr;
        logic        rd;
        logic        wr;
        logic [15:0] wdata;
        logic [7:0]  kcode;
        logic        kstb;
        logic        ack;
        logic [15:0] mem;
        logic [15:0] exp_rd;
        logic        exp_ki;
        logic        exp_di;
        logic        exp_dw;
        logic [7:0]  exp_dc;
        logic [3:0]  req;
    } vec_t;

    // addr rd wr wdata kcode kstb ack mem | exp_rd ki di dw dc req
    localparam vec_t VECS [24] = '{
        '{16'hFE00,1'b1,1'b0,16'h0000,8'h00,1'b0,1'b0,16'h0000, 16'h0000,1'b0,1'b0,1'b0,8'h00,4'd1},  // R1 key status
        '{16'hFE04,1'b1,1'b0,16'h0000,8'h00,1'b0,1'b0,16'h0000, 16'h8000,1'b0,1'b0,1'b0,8'h00,4'd1},  // R1 disp status
        '{16'h3000,1'b1,1'b0,16'h0000,8'h00,1'b0,1'b0,16'hABCD, 16'hABCD,1'b0,1'b0,1'b0,8'h00,4'd10}, // R10
        '{16'h3000,1'b0,1'b0,16'h0000,8'h41,1'b1,1'b0,16'h1234, 16'h1234,1'b0,1'b0,1'b0,8'h00,4'd2},  // R2 char in
        '{16'hFE00,1'b1,1'b0,16'h0000,8'h00,1'b0,1'b0,16'h0000, 16'h8000,1'b0,1'b0,1'b0,8'h00,4'd2},  // R2 ready
        '{16'hFE02,1'b0,1'b0,16'h0000,8'h42,1'b1,1'b0,16'h0000, 16'h0041,1'b0,1'b0,1'b0,8'h00,4'd3},  // R3 dropped
        '{16'hFE02,1'b1,1'b0,16'h0000,8'h43,1'b1,1'b0,16'h0000, 16'h0041,1'b0,1'b0,1'b0,8'h00,4'd3},  // R4 read, R3 strobe lost
        '{16'hFE00,1'b1,1'b0,16'h0000,8'h44,1'b1,1'b0,16'h0000, 16'h0000,1'b0,1'b0,1'b0,8'h00,4'd4},  // R4 cleared
        '{16'hFE02,1'b0,1'b0,16'h0000,8'h00,1'b0,1'b0,16'h0000, 16'h0044,1'b0,1'b0,1'b0,8'h00,4'd4},  // R4 re-enabled
        '{16'hFE00,1'b0,1'b1,16'hFFFF,8'h00,1'b0,1'b0,16'h0000, 16'h8000,1'b0,1'b0,1'b0,8'h00,4'd8},  // R8 write ien
        '{16'hFE00,1'b1,1'b0,16'h0000,8'h00,1'b0,1'b0,16'h0000, 16'hC000,1'b1,1'b0,1'b0,8'h00,4'd8},  // R8 R9
        '{16'hFE00,1'b0,1'b1,16'h0000,8'h00,1'b0,1'b0,16'h0000, 16'hC000,1'b1,1'b0,1'b0,8'h00,4'd8},  // R8 clear ien
        '{16'hFE00,1'b1,1'b0,16'h0000,8'h00,1'b0,1'b0,16'h0000, 16'h8000,1'b0,1'b0,1'b0,8'h00,4'd9},  // R9 irq off
        '{16'hFE04,1'b0,1'b1,16'hFFFF,8'h00,1'b0,1'b0,16'h0000, 16'h8000,1'b0,1'b0,1'b0,8'h00,4'd8},  // R8 disp ien
        '{16'hFE04,1'b1,1'b0,16'h0000,8'h00,1'b0,1'b0,16'h0000, 16'hC000,1'b0,1'b1,1'b0,8'h00,4'd9},  // R9 disp irq
        '{16'hFE06,1'b0,1'b1,16'h1255,8'h00,1'b0,1'b0,16'h0000, 16'h0000,1'b0,1'b1,1'b0,8'h00,4'd5},  // R5 store
        '{16'hFE04,1'b1,1'b0,16'h0000,8'h00,1'b0,1'b0,16'h0000, 16'h4000,1'b0,1'b0,1'b1,8'h55,4'd5},  // R5 strobe
        '{16'hFE06,1'b0,1'b1,16'h0066,8'h00,1'b0,1'b0,16'h0000, 16'h0000,1'b0,1'b0,1'b0,8'h00,4'd6},  // R6 busy store
        '{16'hFE04,1'b1,1'b0,16'h0000,8'h00,1'b0,1'b1,16'h0000, 16'h4000,1'b0,1'b0,1'b0,8'h00,4'd6},  // R6 none, ack
        '{16'hFE04,1'b1,1'b0,16'h0000,8'h00,1'b0,1'b0,16'h0000, 16'hC000,1'b0,1'b1,1'b0,8'h00,4'd7},  // R7 ready
        '{16'hFE02,1'b0,1'b1,16'h00FF,8'h00,1'b0,1'b0,16'h0000, 16'h0044,1'b0,1'b1,1'b0,8'h00,4'd11}, // R11 write kdat
        '{16'hFE02,1'b0,1'b0,16'h0000,8'h00,1'b0,1'b0,16'h0000, 16'h0044,1'b0,1'b1,1'b0,8'h00,4'd11}, // R11 unchanged
        '{16'hFE06,1'b1,1'b0,16'h0000,8'h00,1'b0,1'b0,16'hFFFF, 16'h0000,1'b0,1'b1,1'b0,8'h00,4'd11}, // R11 ddat zero
        '{16'hFE01,1'b1,1'b0,16'h0000,8'h00,1'b0,1'b0,16'h5A5A, 16'h5A5A,1'b0,1'b1,1'b0,8'h00,4'd10}  // R10 odd addr
    };

    // R7 with a simultaneous ignored store, then a fresh accepted store
    localparam vec_t EDGE [5] = '{
        '{16'hFE06,1'b0,1'b1,16'h0077,8'h00,1'b0,1'b0,16'h0000, 16'h0000,1'b0,1'b1,1'b0,8'h00,4'd5},
        '{16'hFE06,1'b0,1'b1,16'h0088,8'h00,1'b0,1'b1,16'h0000, 16'h0000,1'b0,1'b0,1'b1,8'h77,4'd5},
        '{16'hFE04,1'b1,1'b0,16'h0000,8'h00,1'b0,1'b0,16'h0000, 16'hC000,1'b0,1'b1,1'b0,8'h00,4'd7},
        '{16'hFE06,1'b0,1'b1,16'h0099,8'h00,1'b0,1'b0,16'h0000, 16'h0000,1'b0,1'b1,1'b0,8'h00,4'd6},
        '{16'hFE04,1'b1,1'b0,16'h0000,8'h00,1'b0,1'b0,16'h0000, 16'h4000,1'b0,1'b0,1'b1,8'h99,4'd5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] mem_rdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  key_code = '0;
    logic        key_stb = 1'b0;
    logic [7:0]  disp_code;
    logic        disp_stb;
    logic        disp_ack = 1'b0;
    logic        key_irq;
    logic        disp_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    con_io_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .mem_rdata (mem_rdata),
        .bus_rdata (bus_rdata),
        .key_code  (key_code),
        .key_stb   (key_stb),
        .disp_code (disp_code),
        .disp_stb  (disp_stb),
        .disp_ack  (disp_ack),
        .key_irq   (key_irq),
        .disp_irq  (disp_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string what, input int req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_step(input vec_t v);
        @(negedge clk);
        bus_addr  = v.addr;
        bus_rd    = v.rd;
        bus_wr    = v.wr;
        bus_wdata = v.wdata;
        key_code  = v.kcode;
        key_stb   = v.kstb;
        disp_ack  = v.ack;
        mem_rdata = v.mem;
        #1;
        check("read data", int'(v.req), bus_rdata, v.exp_rd);
        check("key irq",   int'(v.req), 16'(key_irq), 16'(v.exp_ki));
        check("disp irq",  int'(v.req), 16'(disp_irq), 16'(v.exp_di));
        check("disp strobe", int'(v.req), 16'(disp_stb), 16'(v.exp_dw));
        if (v.exp_dw) check("disp code", int'(v.req), 16'(disp_code), 16'(v.exp_dc));
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        foreach (VECS[i]) do_step(VECS[i]);
        foreach (EDGE[i]) do_step(EDGE[i]);

        // R1: reset in mid-run (keyboard full, display busy) restores defaults
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; key_stb = 1'b0; disp_ack = 1'b0;
        rst_n = 1'b0;
        bus_addr = 16'hFE00;
        #1;
        check("reset key status", 1, bus_rdata, 16'h0000);
        bus_addr = 16'hFE04;
        #1;
        check("reset disp status", 1, bus_rdata, 16'h8000);
        check("reset key irq", 1, 16'(key_irq), 16'h0);
        check("reset disp irq", 1, 16'(disp_irq), 16'h0);
        check("reset disp strobe", 1, 16'(disp_stb), 16'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: capture works again right after reset
        do_step('{16'h3000,1'b0,1'b0,16'h0000,8'h7E,1'b1,1'b0,16'h0000, 16'h0000,1'b0,1'b0,1'b0,8'h00,4'd2});
        do_step('{16'hFE02,1'b0,1'b0,16'h0000,8'h00,1'b0,1'b0,16'h0000, 16'h007E,1'b0,1'b0,1'b0,8'h00,4'd2});
        finish_run();
    end

endmodule